// File: doc/BRIEF.md
# Register/Memory Operand Address Decoder

This block sits behind an opcode decoder in a variable-length instruction front end. It takes the bytes that follow an opcode, one byte per clock when `in_valid` is high. It parses the operand specifier byte and, in 32-bit addressing, an optional scale-index-base byte. It then collects an 8-, 16- or 32-bit displacement. When the last required byte arrives, it reports one of two results. The first is a register operand selection. The second is a memory effective address formed from a snapshot of the eight general registers supplied on `gpr_flat`.

The addressing width is taken from `addr32` in the same cycle as the first byte and is held for the rest of that operand. All results are valid only in the cycle where `done` is high. That is the same cycle the final byte is presented, so no extra cycle of latency is added. The next byte after `done` is treated as the first byte of a new operand.

Register numbering used throughout: 0 AX/EAX, 1 CX/ECX, 2 DX/EDX, 3 BX/EBX, 4 SP/ESP, 5 BP/EBP, 6 SI/ESI, 7 DI/EDI. Register i occupies `gpr_flat[32*i+31:32*i]`; 16-bit mode uses the low half.

Top module: `modrm_ea_unit`

## Requirements
- R1: The first byte is split as mode = bits 7:6, reg = bits 5:3, rm = bits 2:0. The reg value is presented on `reg_field` when `done` is high.
- R2: Mode 3 means a register operand. In that case `done` rises with the first byte, `is_reg`=1, `rm_reg` equals rm, and `byte_count`=1.
- R3: In 16-bit addressing with mode 0, rm 0..7 give these addresses in order: BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, a direct 16-bit displacement (two more bytes), and BX.
- R4: In 16-bit addressing, mode 1 adds a sign-extended 8-bit displacement to the mode-0 base, and mode 2 adds a 16-bit displacement. For rm 6 in modes 1 and 2 the base is BP.
- R5: A 16-bit address is computed modulo 2^16, and `ea[31:16]` is zero.
- R6: In 32-bit addressing with rm not 4, register rm is the base. Mode 1 adds a sign-extended 8-bit displacement and mode 2 adds a 32-bit displacement.
- R7: In 32-bit addressing, mode 0 with rm 5 is a bare 32-bit displacement with no base. In modes 1 and 2, rm 5 uses EBP as base.
- R8: In 32-bit addressing with mode 0..2 and rm 4, a second byte follows: scale = bits 7:6, index = bits 5:3, base = bits 2:0. The address is base + index·2^scale + displacement.
- R9: An index field of 4 adds no index term, whatever the scale.
- R10: A base field of 5 in mode 0 replaces the base with a 32-bit displacement. In modes 1 and 2, a base field of 5 selects EBP.
- R11: Displacement bytes arrive least-significant first. `done` is high only in the cycle the last required byte is accepted. `byte_count` then gives the total bytes consumed, including the first byte.
- R12: A cycle with `in_valid` low consumes nothing, keeps `done` low and leaves the parse state unchanged.
- R13: A 32-bit address is computed modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present on in_byte this cycle |
| in_byte | input | 8 | Next byte after the opcode |
| addr32 | input | 1 | 1 = 32-bit addressing, sampled with the first byte |
| gpr_flat | input | 256 | Eight 32-bit general registers, register i at bits 32i+31:32i |
| done | output | 1 | Operand fully parsed; other outputs valid |
| byte_count | output | 3 | Bytes consumed for this operand |
| is_reg | output | 1 | Operand is a register, not memory |
| reg_field | output | 3 | The reg field of the first byte |
| rm_reg | output | 3 | Register number when is_reg is set |
| ea | output | 32 | Effective address for a memory operand |

## Verification
The embedded assertions cover rules that must hold on every cycle. Every completion is followed by a return to the first-byte state with a cleared count, and idle cycles hold the parse state. A register operand always completes after one byte, a 16-bit address never has upper bits set, and the second-byte state is only entered for a 32-bit, mode 0..2, rm 4 specifier. Only the directed scenarios can show the address values themselves: the eight 16-bit base pairs, sign extension of short displacements, the bare-displacement substitutions, scaling of the index, the no-index code, and wrap-around. They also show that byte order and gaps between bytes do not change the result.

// File: rtl/modrm_ea_unit.sv
module modrm_ea_unit (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [7:0]   in_byte,
  input  logic         addr32,
  input  logic [255:0] gpr_flat,
  output logic         done,
  output logic [2:0]   byte_count,
  output logic         is_reg,
  output logic [2:0]   reg_field,
  output logic [2:0]   rm_reg,
  output logic [31:0]  ea
);

  typedef enum logic [1:0] {S_MODRM, S_SIB, S_DISP} st_t;

  st_t         st;
  logic [1:0]  mod_r;
  logic [2:0]  reg_r, rm_r;
  logic        m32_r;
  logic [7:0]  sib_r;
  logic [23:0] disp_r;
  logic [1:0]  idx_r;
  logic [2:0]  cnt_r;

  wire        first  = (st == S_MODRM);
  wire [1:0]  mod_c  = first ? in_byte[7:6] : mod_r;
  wire [2:0]  reg_c  = first ? in_byte[5:3] : reg_r;
  wire [2:0]  rm_c   = first ? in_byte[2:0] : rm_r;
  wire        m32_c  = first ? addr32 : m32_r;
  wire [7:0]  sib_c  = (st == S_SIB) ? in_byte : sib_r;
  wire        need_sib = m32_c && (mod_c != 2'd3) && (rm_c == 3'd4);

  function automatic logic [31:0] gr(input logic [2:0] i);
    return gpr_flat[{i, 5'b0} +: 32];
  endfunction

  logic [2:0] dlen;
  always_comb begin
    dlen = 3'd0;
    if (mod_c == 2'd1) dlen = 3'd1;
    else if (mod_c == 2'd2) dlen = m32_c ? 3'd4 : 3'd2;
    else if (mod_c == 2'd0) begin
      if (!m32_c && rm_c == 3'd6) dlen = 3'd2;
      if (m32_c && rm_c == 3'd5) dlen = 3'd4;
      if (m32_c && rm_c == 3'd4 && sib_c[2:0] == 3'd5) dlen = 3'd4;
    end
  end

  always_comb begin
    case (st)
      S_MODRM: done = in_valid && !need_sib && (dlen == 3'd0);
      S_SIB:   done = in_valid && (dlen == 3'd0);
      S_DISP:  done = in_valid && ({1'b0, idx_r} + 3'd1 == dlen);
      default: done = 1'b0;
    endcase
  end

  logic [31:0] disp_raw, disp;
  always_comb begin
    disp_raw = 32'd0;
    if (st == S_DISP) begin
      case (idx_r)
        2'd0: disp_raw = {24'd0, in_byte};
        2'd1: disp_raw = {16'd0, in_byte, disp_r[7:0]};
        2'd2: disp_raw = {8'd0, in_byte, disp_r[15:0]};
        default: disp_raw = {in_byte, disp_r};
      endcase
    end
    disp = (dlen == 3'd1) ? {{24{disp_raw[7]}}, disp_raw[7:0]} : disp_raw;
  end

  logic [15:0] b16, ea16;
  logic [31:0] base32, index32;
  wire  [1:0]  sc = sib_c[7:6];
  wire  [2:0]  ix = sib_c[5:3];
  wire  [2:0]  bs = sib_c[2:0];

  always_comb begin
    case (rm_c)
      3'd0: b16 = gr(3'd3)[15:0] + gr(3'd6)[15:0];
      3'd1: b16 = gr(3'd3)[15:0] + gr(3'd7)[15:0];
      3'd2: b16 = gr(3'd5)[15:0] + gr(3'd6)[15:0];
      3'd3: b16 = gr(3'd5)[15:0] + gr(3'd7)[15:0];
      3'd4: b16 = gr(3'd6)[15:0];
      3'd5: b16 = gr(3'd7)[15:0];
      3'd6: b16 = (mod_c == 2'd0) ? 16'd0 : gr(3'd5)[15:0];
      default: b16 = gr(3'd3)[15:0];
    endcase
    ea16 = b16 + disp[15:0];
    if (rm_c == 3'd4) begin
      base32  = (mod_c == 2'd0 && bs == 3'd5) ? 32'd0 : gr(bs);
      index32 = (ix == 3'd4) ? 32'd0 : (gr(ix) << sc);
    end else begin
      base32  = (mod_c == 2'd0 && rm_c == 3'd5) ? 32'd0 : gr(rm_c);
      index32 = 32'd0;
    end
  end

  assign ea         = m32_c ? (base32 + index32 + disp) : {16'd0, ea16};
  assign is_reg     = (mod_c == 2'd3);
  assign reg_field  = reg_c;
  assign rm_reg     = rm_c;
  assign byte_count = cnt_r + 3'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_MODRM; cnt_r <= 3'd0; idx_r <= 2'd0;
      mod_r <= 2'd0; reg_r <= 3'd0; rm_r <= 3'd0; m32_r <= 1'b0;
      sib_r <= 8'd0; disp_r <= 24'd0;
    end else if (in_valid) begin
      if (done) begin
        st <= S_MODRM; cnt_r <= 3'd0; idx_r <= 2'd0; disp_r <= 24'd0;
      end else begin
        cnt_r <= cnt_r + 3'd1;
        case (st)
          S_MODRM: begin
            mod_r <= mod_c; reg_r <= reg_c; rm_r <= rm_c; m32_r <= m32_c;
            st <= need_sib ? S_SIB : S_DISP;
            idx_r <= 2'd0;
          end
          S_SIB: begin
            sib_r <= in_byte; st <= S_DISP; idx_r <= 2'd0;
          end
          default: begin
            case (idx_r)
              2'd0: disp_r[7:0]   <= in_byte;
              2'd1: disp_r[15:8]  <= in_byte;
              default: disp_r[23:16] <= in_byte;
            endcase
            idx_r <= idx_r + 2'd1;
          end
        endcase
      end
    end
  end

  // R11
  done_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (st == S_MODRM && cnt_r == 3'd0));
  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(st) && $stable(cnt_r) && $stable(idx_r)));
  // R2
  reg_one_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_reg) |-> (byte_count == 3'd1));
  // R5
  wrap16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !m32_c) |-> (ea[31:16] == 16'd0 && byte_count <= 3'd3));
  // R8
  sib_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SIB) |-> (m32_r && mod_r != 2'd3 && rm_r == 3'd4));

endmodule

// File: tb/tb_modrm_ea_unit.sv
module tb_modrm_ea_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [7:0]   in_byte = 8'd0;
  logic         addr32 = 1'b0;
  logic [255:0] gpr_flat;
  logic         done, is_reg;
  logic [2:0]   byte_count, reg_field, rm_reg;
  logic [31:0]  ea;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  modrm_ea_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .addr32(addr32), .gpr_flat(gpr_flat), .done(done), .byte_count(byte_count),
    .is_reg(is_reg), .reg_field(reg_field), .rm_reg(rm_reg), .ea(ea)
  );

  initial begin
    gpr_flat[0*32 +: 32] = 32'h0000_1000;
    gpr_flat[1*32 +: 32] = 32'h0000_0200;
    gpr_flat[2*32 +: 32] = 32'h0000_0030;
    gpr_flat[3*32 +: 32] = 32'h0000_4000;
    gpr_flat[4*32 +: 32] = 32'h0000_8000;
    gpr_flat[5*32 +: 32] = 32'h0001_2000;
    gpr_flat[6*32 +: 32] = 32'h0000_0005;
    gpr_flat[7*32 +: 32] = 32'h0000_0050;
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // Sends n bytes (byte k = bytes[8k+:8]) with gap idle cycles between them.
  task automatic run(input string req, input logic m32, input int n, input logic [47:0] bytes,
                     input int gap, input logic [31:0] exp_ea, input logic [2:0] exp_reg,
                     input logic [2:0] exp_cnt);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_byte = bytes[8*k +: 8]; addr32 = m32;
      #2;
      if (k < n - 1) chk(req, "early done", {31'd0, done}, 32'd0);
      else begin
        chk(req, "done", {31'd0, done}, 32'd1);
        chk(req, "is_reg", {31'd0, is_reg}, 32'd0);
        chk(req, "reg_field", {29'd0, reg_field}, {29'd0, exp_reg});
        chk(req, "byte_count", {29'd0, byte_count}, {29'd0, exp_cnt});
        chk(req, "ea", ea, exp_ea);
      end
      if (k < n - 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0; in_byte = 8'hFF; addr32 = ~m32;
          #2;
          chk("R12", "done during gap", {31'd0, done}, 32'd0);
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); #2;
    chk("R11", "done after reset", {31'd0, done}, 32'd0);
  endtask

  task automatic t_regop;
    @(negedge clk);
    in_valid = 1'b1; in_byte = 8'hD3; addr32 = 1'b1;
    #2;
    chk("R2", "done", {31'd0, done}, 32'd1);
    chk("R2", "is_reg", {31'd0, is_reg}, 32'd1);
    chk("R1", "reg_field", {29'd0, reg_field}, 32'd2);
    chk("R2", "rm_reg", {29'd0, rm_reg}, 32'd3);
    chk("R2", "byte_count", {29'd0, byte_count}, 32'd1);
    @(negedge clk);
    in_valid = 1'b1; in_byte = 8'hFE; addr32 = 1'b0;
    #2;
    chk("R2", "16b done", {31'd0, done}, 32'd1);
    chk("R1", "16b reg_field", {29'd0, reg_field}, 32'd7);
    chk("R2", "16b rm_reg", {29'd0, rm_reg}, 32'd6);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_mode16_base;
    logic [31:0] e;
    for (int r = 0; r < 8; r++) begin
      case (r)
        0: e = 32'h4005; 1: e = 32'h4050; 2: e = 32'h2005; 3: e = 32'h2050;
        4: e = 32'h0005; 5: e = 32'h0050; 6: e = 32'h1234; default: e = 32'h4000;
      endcase
      if (r == 6) run("R3", 1'b0, 3, {24'd0, 8'h12, 8'h34, 8'h06}, 0, e, 3'd0, 3'd3);
      else run("R3", 1'b0, 1, {40'd0, 2'b00, 3'(7 - r), 3'(r)}, 0, e, 3'(7 - r), 3'd1);
    end
  endtask

  task automatic t_mode16_disp;
    run("R4", 1'b0, 2, {32'd0, 8'hF0, 8'h47}, 0, 32'h3FF0, 3'd0, 3'd2);
    run("R4", 1'b0, 3, {24'd0, 8'h01, 8'h00, 8'h86}, 0, 32'h2100, 3'd0, 3'd3);
    run("R4", 1'b0, 2, {32'd0, 8'h10, 8'h46}, 0, 32'h2010, 3'd0, 3'd2);
  endtask

  task automatic t_wrap16;
    run("R5", 1'b0, 3, {24'd0, 8'hFF, 8'hFF, 8'h84}, 0, 32'h0004, 3'd0, 3'd3);
  endtask

  task automatic t_mode32_base;
    run("R6", 1'b1, 1, {40'd0, 8'h03}, 0, 32'h4000, 3'd0, 3'd1);
    run("R6", 1'b1, 2, {32'd0, 8'hFE, 8'h41}, 0, 32'h01FE, 3'd0, 3'd2);
    run("R6", 1'b1, 5, {8'd0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h86}, 0, 32'h1234567D, 3'd0, 3'd5);
  endtask

  task automatic t_direct32;
    run("R7", 1'b1, 5, {8'd0, 8'hCA, 8'hFE, 8'hBA, 8'hBE, 8'h05}, 0, 32'hCAFEBABE, 3'd0, 3'd5);
    run("R7", 1'b1, 2, {32'd0, 8'h04, 8'h45}, 0, 32'h0001_2004, 3'd0, 3'd2);
  endtask

  task automatic t_sib;
    run("R8", 1'b1, 2, {32'd0, 8'h8B, 8'h04}, 0, 32'h4800, 3'd0, 3'd2);
    run("R8", 1'b1, 2, {32'd0, 8'hF0, 8'h04}, 0, 32'h1028, 3'd0, 3'd2);
  endtask

  task automatic t_noindex;
    run("R9", 1'b1, 2, {32'd0, 8'h63, 8'h04}, 0, 32'h4000, 3'd0, 3'd2);
  endtask

  task automatic t_sib_base5;
    run("R10", 1'b1, 6, {8'h00, 8'h10, 8'h00, 8'h00, 8'h3D, 8'h04}, 0, 32'h0010_0050, 3'd0, 3'd6);
    run("R10", 1'b1, 3, {24'd0, 8'h08, 8'h3D, 8'h44}, 0, 32'h0001_2058, 3'd0, 3'd3);
  endtask

  task automatic t_wrap32;
    run("R13", 1'b1, 5, {8'd0, 8'hFF, 8'hFF, 8'hF0, 8'h00, 8'h80}, 0, 32'h0000_0000, 3'd0, 3'd5);
  endtask

  task automatic t_stall;
    run("R12", 1'b1, 6, {8'h00, 8'h00, 8'h00, 8'h10, 8'h8B, 8'h84}, 3, 32'h0000_4810, 3'd0, 3'd6);
  endtask

  task automatic t_lsb_first;
    run("R11", 1'b1, 5, {8'd0, 8'h01, 8'h00, 8'h00, 8'h00, 8'h86}, 0, 32'h0100_0005, 3'd0, 3'd5);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_regop();
    t_mode16_base();
    t_mode16_disp();
    t_wrap16();
    t_mode32_base();
    t_direct32();
    t_sib();
    t_noindex();
    t_sib_base5();
    t_wrap32();
    t_stall();
    t_lsb_first();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule